// File: doc/BRIEF.md
# Quadrature and Pulse Event Counter Timer

This block is a small timer peripheral on a simple register bus. It counts in one of three ways. It can count every system clock. It can count selected edges of one external input. It can decode two phase inputs from a rotary or linear encoder and count up or down. Both external inputs pass through a two-stage synchronizer before any edge is detected. Edges that arrive closer together than one system clock may be lost.

A three-state controller sequences the block:

- **OFF** (disabled): configuration may be changed, and compare or reload writes are dropped.
- **IDLE** (enabled, armed): compare and reload may be written, and every accepted write raises a sticky completion flag.
- **RUN**: the counter is live and wraps continuously at the ceiling.

The controller has four transitions:

- **T_ENABLE** (OFF to IDLE): clears the count.
- **T_START** (IDLE to RUN).
- **T_DISABLE** (IDLE to OFF).
- **T_STOP** (RUN to OFF): freezes the count, which stays readable.

Software reads the count and the status flags at any time. It clears the flags by writing ones to a separate clear register.

Register offsets on the 3-bit address: 0 control, 1 configuration, 2 compare, 3 reload (ceiling), 4 count (read only), 5 status (read only), 6 flag clear (write-one-to-clear, reads 0). Read data is registered and appears the clock after the read strobe.

Top module: `lpenc_timer`

## Requirements
- R1: After reset the control reads 0, configuration 0, compare 0, count 0, status 0, and the reload ceiling reads all ones (0xFFFF).
- R2: Control bit 0 is enable and bit 1 is start. A start is honoured only from IDLE, so a write of 3 from OFF only reaches IDLE. Entering IDLE clears the count to 0. Control reads back bit 0 = enabled and bit 1 = running.
- R3: Writes to compare (offset 2) and reload (offset 3) are ignored while disabled and accepted while enabled.
- R4: An accepted compare write sets status bit 0 and an accepted reload write sets status bit 1. Each stays set until a 1 is written to the same bit position of the clear register (offset 6). Other clear bits leave it unchanged.
- R5: Configuration holds encoder select in bit 0, external-count select in bit 1, edge polarity in bits 3:2 and a prescaler in bits 6:4. It is writable only while disabled. The prescaler is always divide-by-1 and its field reads back 0.
- R6: With bits 1:0 of the configuration both 0, the count advances once per clock while running. After it reaches the ceiling it wraps to 0.
- R7: In external-count mode (configuration bits 1:0 = 2'b10), only edges of input A step the count up, following the polarity code. Code 0 selects rising edges, 1 falling edges, 2 both edges and 3 no edges. Input B has no effect.
- R8: In encoder mode (bit 0 = 1) with polarity 2, every transition of either phase counts. The count goes up when A leads B (AB sequence 00,10,11,01) and down when B leads A.
- R9: In encoder mode, polarity 0 counts only rising transitions of either phase and polarity 1 only falling ones, giving two counts per cycle. Polarity 3 counts nothing.
- R10: Stepping down from 0 loads the ceiling.
- R11: Status bit 2 sets when the count steps onto the compare value. Status bit 3 sets on every wrap in either direction. Both are sticky and cleared through the clear register.
- R12: After T_STOP the count holds its value and stays readable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_a | input | 1 | External input A (pulse input or phase A) |
| in_b | input | 1 | External input B (phase B) |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe, one clock per write |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 16 | Registered read data, valid the clock after bus_re |

## Verification
A wrong controller state appears on the control readback at the very next read. The count also drifts, or fails to, between two reads taken a few clocks apart. A fault in the synchronizer or in the decode shows as a final count that differs from the arithmetic tally of edges for that polarity and direction, once the last input change has settled three clocks later. Flag faults show in the status word read right after the write or the count step that should have set or cleared them.

// File: rtl/lpenc_pkg.sv
package lpenc_pkg;

    localparam int ADDR_W = 3;
    localparam int CFG_W  = 7;
    localparam int STAT_W = 4;

    // register offsets
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_CFG    = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMP    = 3'd2;
    localparam logic [ADDR_W-1:0] A_RELOAD = 3'd3;
    localparam logic [ADDR_W-1:0] A_COUNT  = 3'd4;
    localparam logic [ADDR_W-1:0] A_STAT   = 3'd5;
    localparam logic [ADDR_W-1:0] A_CLR    = 3'd6;

    // control bits
    localparam int CTRL_EN    = 0;
    localparam int CTRL_START = 1;

    // status bits
    localparam int SB_CMPOK = 0;
    localparam int SB_RELOK = 1;
    localparam int SB_MATCH = 2;
    localparam int SB_WRAP  = 3;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_IDLE = 2'd1,
        ST_RUN  = 2'd2
    } run_state_e;

    typedef enum logic [1:0] {
        POL_RISE = 2'd0,
        POL_FALL = 2'd1,
        POL_BOTH = 2'd2,
        POL_NONE = 2'd3
    } edge_pol_e;

    typedef struct packed {
        logic [2:0] presc;
        edge_pol_e  pol;
        logic       ext_cnt;
        logic       enc;
    } cfg_t;

endpackage

// File: rtl/lpenc_edge_sync.sv
module lpenc_edge_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pins,
    output logic [N-1:0] lvl,
    output logic [N-1:0] lvl_q
);

    generate
        for (genvar i = 0; i < N; i++) begin : g_ch
            logic meta_r, sync_r, hist_r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    meta_r <= 1'b0;
                    sync_r <= 1'b0;
                    hist_r <= 1'b0;
                end else begin
                    meta_r <= pins[i];
                    sync_r <= meta_r;
                    hist_r <= sync_r;
                end
            end
            assign lvl[i]   = sync_r;
            assign lvl_q[i] = hist_r;
        end
    endgenerate

endmodule

// File: rtl/lpenc_step_gen.sv
module lpenc_step_gen
    import lpenc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enc,
    input  logic       ext_cnt,
    input  edge_pol_e  pol,
    input  logic [1:0] lvl,
    input  logic [1:0] lvl_q,
    output logic       step_up,
    output logic       step_dn
);

    logic a_now, b_now, a_old, b_old, a_chg, b_chg, hit;

    assign a_now = lvl[0];
    assign b_now = lvl[1];
    assign a_old = lvl_q[0];
    assign b_old = lvl_q[1];
    assign a_chg = a_now ^ a_old;
    assign b_chg = b_now ^ b_old;

    function automatic logic pol_hit(input edge_pol_e p, input logic nv);
        case (p)
            POL_RISE: return nv;
            POL_FALL: return !nv;
            POL_BOTH: return 1'b1;
            default:  return 1'b0;
        endcase
    endfunction

    always_comb begin
        step_up = 1'b0;
        step_dn = 1'b0;
        hit     = 1'b0;
        if (enc) begin
            if (a_chg ^ b_chg) begin
                hit = a_chg ? pol_hit(pol, a_now) : pol_hit(pol, b_now);
                if (hit) begin
                    if (a_now ^ b_old) step_up = 1'b1;
                    else               step_dn = 1'b1;
                end
            end
        end else if (ext_cnt) begin
            step_up = a_chg && pol_hit(pol, a_now);
        end else begin
            step_up = 1'b1;
        end
    end

    // R7: input B alone never produces a step in external-count mode
    p_b_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!enc && ext_cnt && (lvl[0] == lvl_q[0])) |-> (!step_up && !step_dn));

    // R9: polarity code 3 suppresses encoder steps
    p_pol_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (enc && pol == POL_NONE) |-> (!step_up && !step_dn));

endmodule

// File: rtl/lpenc_counter.sv
module lpenc_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         run,
    input  logic         step_up,
    input  logic         step_dn,
    input  logic [W-1:0] ceil,
    input  logic [W-1:0] cmp,
    output logic [W-1:0] cnt,
    output logic         hit_cmp,
    output logic         hit_wrap
);

    logic [W-1:0] nxt;
    logic         wrap, step;

    always_comb begin
        nxt  = cnt;
        wrap = 1'b0;
        if (step_up) begin
            wrap = (cnt >= ceil);
            nxt  = wrap ? '0 : cnt + W'(1);
        end else if (step_dn) begin
            wrap = (cnt == '0);
            nxt  = wrap ? ceil : cnt - W'(1);
        end
    end

    assign step     = run && (step_up || step_dn);
    assign hit_cmp  = step && (nxt == cmp);
    assign hit_wrap = step && wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (clear) cnt <= '0;
        else if (step)  cnt <= nxt;
    end

    // R6: counting up from the ceiling lands on zero
    p_wrap_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && step_up && !clear && cnt >= ceil) |=> (cnt == '0));

    // R10: counting down from zero lands on the ceiling
    p_wrap_dn_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !step_up && step_dn && !clear && cnt == '0) |=> (cnt == $past(ceil)));

    // R12: a stopped counter keeps its value
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clear) |=> $stable(cnt));

endmodule

// File: rtl/lpenc_timer.sv
module lpenc_timer
    import lpenc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_a,
    input  logic              in_b,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [CNT_W-1:0]  bus_rdata
);

    localparam logic [CNT_W-1:0] CEIL_MAX = '1;

    run_state_e          state_q, state_d;
    cfg_t                cfg_q;
    logic [CNT_W-1:0]    cmp_q, rel_q, cnt, rd_mux;
    logic [STAT_W-1:0]   stat_q, stat_set, stat_clr;
    logic                wr_ctrl, wr_cfg, wr_cmp, wr_rel, wr_clr;
    logic                en, run, clr_cnt;
    logic [1:0]          lvl, lvl_q;
    logic                step_up, step_dn, hit_cmp, hit_wrap;

    assign wr_ctrl = bus_we && (bus_addr == A_CTRL);
    assign wr_cfg  = bus_we && (bus_addr == A_CFG);
    assign wr_cmp  = bus_we && (bus_addr == A_CMP);
    assign wr_rel  = bus_we && (bus_addr == A_RELOAD);
    assign wr_clr  = bus_we && (bus_addr == A_CLR);

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // ---------------- transitions ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (wr_ctrl && bus_wdata[CTRL_EN]) state_d = ST_IDLE;      // T_ENABLE
            end
            ST_IDLE: begin
                if (wr_ctrl) begin
                    if (!bus_wdata[CTRL_EN])         state_d = ST_OFF;     // T_DISABLE
                    else if (bus_wdata[CTRL_START])  state_d = ST_RUN;     // T_START
                end
            end
            ST_RUN: begin
                if (wr_ctrl && !bus_wdata[CTRL_EN]) state_d = ST_OFF;      // T_STOP
            end
            default: state_d = ST_OFF;
        endcase
    end

    // ---------------- state outputs ----------------
    always_comb begin
        en      = 1'b0;
        run     = 1'b0;
        clr_cnt = 1'b0;
        unique case (state_q)
            ST_OFF:  clr_cnt = (state_d == ST_IDLE);
            ST_IDLE: en      = 1'b1;
            ST_RUN:  begin en = 1'b1; run = 1'b1; end
            default: ;
        endcase
    end

    // ---------------- configuration and limits ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_cfg && !en) begin
            cfg_q <= '{presc:   3'd0,
                       pol:     edge_pol_e'(bus_wdata[3:2]),
                       ext_cnt: bus_wdata[1],
                       enc:     bus_wdata[0]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= '0;
            rel_q <= CEIL_MAX;
        end else begin
            if (wr_cmp && en) cmp_q <= bus_wdata;
            if (wr_rel && en) rel_q <= bus_wdata;
        end
    end

    // ---------------- status flags ----------------
    always_comb begin
        stat_set           = '0;
        stat_set[SB_CMPOK] = wr_cmp && en;
        stat_set[SB_RELOK] = wr_rel && en;
        stat_set[SB_MATCH] = hit_cmp;
        stat_set[SB_WRAP]  = hit_wrap;
        stat_clr           = wr_clr ? bus_wdata[STAT_W-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~stat_clr) | stat_set;
    end

    // ---------------- read path ----------------
    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            A_CTRL: begin
                rd_mux[CTRL_EN]    = en;
                rd_mux[CTRL_START] = run;
            end
            A_CFG:    rd_mux[CFG_W-1:0]  = cfg_q;
            A_CMP:    rd_mux             = cmp_q;
            A_RELOAD: rd_mux             = rel_q;
            A_COUNT:  rd_mux             = cnt;
            A_STAT:   rd_mux[STAT_W-1:0] = stat_q;
            default:  rd_mux             = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_mux;
    end

    // ---------------- datapath ----------------
    lpenc_edge_sync #(.N(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pins  ({in_b, in_a}),
        .lvl   (lvl),
        .lvl_q (lvl_q)
    );

    lpenc_step_gen u_step (
        .clk     (clk),
        .rst_n   (rst_n),
        .enc     (cfg_q.enc),
        .ext_cnt (cfg_q.ext_cnt),
        .pol     (cfg_q.pol),
        .lvl     (lvl),
        .lvl_q   (lvl_q),
        .step_up (step_up),
        .step_dn (step_dn)
    );

    lpenc_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clr_cnt),
        .run      (run),
        .step_up  (step_up),
        .step_dn  (step_dn),
        .ceil     (rel_q),
        .cmp      (cmp_q),
        .cnt      (cnt),
        .hit_cmp  (hit_cmp),
        .hit_wrap (hit_wrap)
    );

    // ---------------- assertions ----------------
    // R2: OFF never jumps straight to RUN
    p_start_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF) |=> (state_q != ST_RUN));

    // R3: limit writes while disabled leave the limits alone
    p_rel_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && wr_rel) |=> $stable(rel_q));
    p_cmp_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && wr_cmp) |=> $stable(cmp_q));

    // R4: completion flag survives until its clear bit is written
    p_cmpok_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[SB_CMPOK] && !(wr_clr && bus_wdata[SB_CMPOK])) |=> stat_q[SB_CMPOK]);

    // R5: configuration is frozen while enabled
    p_cfg_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_OFF) |=> $stable(cfg_q));

endmodule

// File: tb/lpenc_timer_tb.sv
`timescale 1ns/1ps
module lpenc_timer_tb;

    localparam logic [2:0] R_CTRL = 3'd0, R_CFG = 3'd1, R_CMP = 3'd2, R_REL = 3'd3,
                           R_CNT = 3'd4, R_STAT = 3'd5, R_CLR = 3'd6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_a = 1'b0, in_b = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_we = 1'b0, bus_re = 1'b0;
    logic [15:0] bus_rdata;

    int n_chk = 0, n_fail = 0;
    int pos, exp_cnt, wrapped, m, steps, e_wp, e_mt;
    logic [15:0] rv, rv2;

    always #4 clk = ~clk;

    lpenc_timer u_dut (
        .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_re(bus_re), .bus_rdata(bus_rdata)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic set_pins(input logic a, input logic b);
        @(negedge clk);
        in_a = a; in_b = b;
        repeat (4) @(negedge clk);
    endtask

    function automatic logic ph_a(input int i); return (i == 1 || i == 2); endfunction
    function automatic logic ph_b(input int i); return (i == 2 || i == 3); endfunction

    task automatic enc_step(input bit fwd, input int pol, input int ceil);
        int  np;
        logic an, bn, nv, hit;
        np  = fwd ? (pos + 1) % 4 : (pos + 3) % 4;
        an  = ph_a(np);
        bn  = ph_b(np);
        nv  = (an != ph_a(pos)) ? an : bn;
        hit = (pol == 2) || (pol == 0 && nv) || (pol == 1 && !nv);
        if (hit) begin
            if (fwd) begin
                if (exp_cnt >= ceil) begin exp_cnt = 0; wrapped = 1; end
                else exp_cnt++;
            end else begin
                if (exp_cnt == 0) begin exp_cnt = ceil; wrapped = 1; end
                else exp_cnt--;
            end
        end
        pos = np;
        set_pins(an, bn);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd(R_CTRL, rv); check("R1 ctrl", rv, 16'h0000);
        rd(R_CFG,  rv); check("R1 cfg", rv, 16'h0000);
        rd(R_CMP,  rv); check("R1 cmp", rv, 16'h0000);
        rd(R_REL,  rv); check("R1 reload", rv, 16'hFFFF);
        rd(R_CNT,  rv); check("R1 count", rv, 16'h0000);
        rd(R_STAT, rv); check("R1 status", rv, 16'h0000);

        // R3 writes while disabled are dropped
        wr(R_REL, 16'd5); wr(R_CMP, 16'd9);
        rd(R_REL,  rv); check("R3 reload ignored", rv, 16'hFFFF);
        rd(R_CMP,  rv); check("R3 cmp ignored", rv, 16'h0000);
        rd(R_STAT, rv); check("R3 no flags", rv, 16'h0000);

        // R2 start only from IDLE, enable clears count; R12 hold
        wr(R_CTRL, 16'd3);
        rd(R_CTRL, rv); check("R2 start from off gives idle", rv, 16'd1);
        repeat (10) @(negedge clk);
        rd(R_CNT, rv); check("R2 idle does not count", rv, 16'd0);
        wr(R_CTRL, 16'd3);
        rd(R_CTRL, rv); check("R2 running", rv, 16'd3);
        wr(R_CTRL, 16'd0);
        rd(R_CTRL, rv); check("R2 stopped", rv, 16'd0);
        rd(R_CNT, rv);  check("R12 count advanced", {15'd0, rv != 0}, 16'd1);
        repeat (10) @(negedge clk);
        rd(R_CNT, rv2); check("R12 count held", rv2, rv);
        wr(R_CTRL, 16'd1);
        rd(R_CNT, rv); check("R2 enable clears count", rv, 16'd0);

        // R4 completion flags
        wr(R_CLR, 16'hF);
        wr(R_CMP, 16'd5);
        rd(R_STAT, rv); check("R4 cmp ok", rv, 16'h1);
        wr(R_REL, 16'd7);
        rd(R_STAT, rv); check("R4 both ok", rv, 16'h3);
        wr(R_CLR, 16'h2);
        rd(R_STAT, rv); check("R4 partial clear", rv, 16'h1);
        wr(R_CLR, 16'h1);
        rd(R_STAT, rv); check("R4 cleared", rv, 16'h0);
        rd(R_CMP, rv); check("R3 cmp accepted", rv, 16'd5);
        rd(R_REL, rv); check("R3 reload accepted", rv, 16'd7);

        // R5 configuration
        wr(R_CTRL, 16'd0);
        wr(R_CFG, 16'h0076);
        rd(R_CFG, rv); check("R5 prescaler reads 0", rv, 16'h0006);
        wr(R_CTRL, 16'd1);
        wr(R_CFG, 16'h0001);
        rd(R_CFG, rv); check("R5 frozen while enabled", rv, 16'h0006);
        wr(R_CTRL, 16'd0);
        wr(R_CFG, 16'h0000);

        // R6 / R11 internal clock sweep
        for (int c = 0; c < 8; c++) begin
            for (int k = 0; k < 2; k++) begin
                m = (k == 1) ? 2 * c + 3 : c;
                steps = m + 2;
                wr(R_CTRL, 16'd0); wr(R_CTRL, 16'd1);
                wr(R_REL, 16'(c)); wr(R_CMP, 16'(c)); wr(R_CLR, 16'hF);
                wr(R_CTRL, 16'd3);
                repeat (m) @(negedge clk);
                wr(R_CTRL, 16'd0);
                e_wp = (steps > c) ? 1 : 0;
                e_mt = (steps >= ((c == 0) ? 1 : c)) ? 1 : 0;
                rd(R_CNT, rv);  check("R6 wrap count", rv, 16'(steps % (c + 1)));
                rd(R_STAT, rv); check("R11 match/wrap flags", rv, 16'((e_wp << 3) | (e_mt << 2)));
                wr(R_CLR, 16'hC);
                rd(R_STAT, rv); check("R11 flags cleared", rv, 16'h0);
            end
        end

        // R7 external pulse counting sweep
        for (int p = 0; p < 4; p++) begin
            wr(R_CTRL, 16'd0); set_pins(1'b0, 1'b0);
            wr(R_CFG, 16'((p << 2) | 2));
            wr(R_CTRL, 16'd1); wr(R_REL, 16'hFFFF); wr(R_CMP, 16'd2); wr(R_CLR, 16'hF);
            wr(R_CTRL, 16'd3);
            set_pins(1'b0, 1'b1); set_pins(1'b0, 1'b0);
            rd(R_CNT, rv); check("R7 input B ignored", rv, 16'd0);
            exp_cnt = 0;
            for (int i = 0; i < 5; i++) begin
                set_pins(~in_a, in_b);
                if (p == 2 || (p == 0 && in_a) || (p == 1 && !in_a)) exp_cnt++;
                set_pins(in_a, ~in_b);
            end
            wr(R_CTRL, 16'd0);
            rd(R_CNT, rv);  check("R7 edge count", rv, 16'(exp_cnt));
            rd(R_STAT, rv); check("R11 match in pulse mode", rv, 16'((exp_cnt >= 2) ? 4 : 0));
        end

        // R8 / R9 / R10 encoder sweep
        for (int p = 0; p < 4; p++) begin
            wr(R_CTRL, 16'd0); set_pins(1'b0, 1'b0);
            wr(R_CFG, 16'((p << 2) | 1));
            wr(R_CTRL, 16'd1); wr(R_REL, 16'd9); wr(R_CMP, 16'hFFFF); wr(R_CLR, 16'hF);
            wr(R_CTRL, 16'd3);
            pos = 0; exp_cnt = 0; wrapped = 0;
            for (int i = 0; i < 3; i++) enc_step(1'b0, p, 9);
            rd(R_CNT, rv); check("R10 down through zero", rv, 16'(exp_cnt));
            for (int i = 0; i < 8; i++) enc_step(1'b1, p, 9);
            for (int i = 0; i < 2; i++) enc_step(1'b0, p, 9);
            wr(R_CTRL, 16'd0);
            rd(R_CNT, rv);
            if (p == 2) check("R8 x4 count", rv, 16'(exp_cnt));
            else        check("R9 x2 count", rv, 16'(exp_cnt));
            rd(R_STAT, rv); check("R11 encoder wrap flag", rv, 16'(wrapped << 3));
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule